// File: doc/BRIEF.md
# Vernier Delay-Line Tap Setting Sequencer

This block converts a requested interval, given as a coarse count and a fine count, into per-element tap settings for two chained delay lines. One line launches the leading edge and the other launches the trailing edge. Each line is split into a long coarse stage followed by a short fine stage. The leading-edge line runs its coarse stage at zero taps. The trailing-edge line's coarse stage carries the whole coarse count. Both fine stages receive the same fine count. The interval is therefore a coarse tap-count difference plus a Vernier difference that comes from the two lines' slightly different tap delays.

Both lines are tapped only at their final element, so the fixed zero-tap delay of each element appears equally on both paths and cancels. A count is spread over a stage's elements in ascending order. Each element takes a full 31 taps while the remainder allows, one element takes what is left, and the rest take zero.

The settings leave the block as a stream of beats under a valid/ready handshake, leading-edge line first. A one-cycle done pulse closes each update. A request whose counts cannot be represented raises an error pulse and produces no beats.

Top module: `dtc_tap_sequencer`

## Requirements
- R1: After synchronous active-high reset, `req_ready` is 1 and `out_valid`, `done` and `err` are 0.
- R2: An accepted request yields exactly 2×240 beats. The first 240 have `out_line`=0 (leading-edge line) with `out_index` running 0 to 239. The next 240 have `out_line`=1 (trailing-edge line) with `out_index` running 0 to 239.
- R3: Every beat with `out_line`=0 and `out_index` below 237 carries `out_taps`=0.
- R4: The trailing-line coarse beats (`out_line`=1, index 0 to 236) carry the coarse count spread in order. An element at stage position k gets min(31, max(0, coarse − 31k)) taps, so these beats sum to the coarse count.
- R5: The fine beats (index 237 to 239) of both lines carry the fine count spread by the same rule with k = index − 237, so both lines' fine totals are equal.
- R6: While `out_valid` is 1 and `out_ready` is 0, the beat holds unchanged on the next cycle.
- R7: `req_ready` is 1 only when idle. A request presented while beats are streaming has no effect on the stream.
- R8: `done` is 1 for exactly one cycle, in the cycle after the final trailing-line beat is accepted. The block is idle in the cycle after that.
- R9: A request with coarse count above 237×31 = 7347 or fine count above 3×31 = 93 produces a one-cycle `err` pulse in the next cycle and no beats. The block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_coarse | input | 13 | Coarse tap-count difference |
| req_fine | input | 7 | Fine tap count for both fine stages |
| req_ready | output | 1 | Block idle and able to take a request |
| err | output | 1 | One-cycle pulse for a rejected request |
| out_valid | output | 1 | Setting beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_line | output | 1 | 0 = leading-edge line, 1 = trailing-edge line |
| out_index | output | 8 | Element position within the line |
| out_taps | output | 5 | Tap setting for that element |
| done | output | 1 | One-cycle pulse ending an update |

## Verification
The assertions check the following on every cycle: zero taps in the leading line's coarse stage, beat stability under stall, in-order index advance across the line switch, mutual exclusion of streaming and request acceptance, and the single-cycle shape of the done and error pulses. The tap values in the trailing coarse stage and in both fine stages follow from the requested counts. Only the bench's scenarios can show these, by comparing every beat and each stage's total against the fill rule. The same applies to ignoring requests that arrive mid-stream and to the exact range limits.

// File: rtl/dtc_pkg.sv
`timescale 1ns/1ps
package dtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_DONE   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/dtc_req_check.sv
`timescale 1ns/1ps
// Range check on an incoming request.
module dtc_req_check #(
    parameter int COARSE_W   = 13,
    parameter int FINE_W     = 7,
    parameter int COARSE_MAX = 7347,
    parameter int FINE_MAX   = 93
) (
    input  logic [COARSE_W-1:0] coarse,
    input  logic [FINE_W-1:0]   fine,
    output logic                in_range
);
    always_comb begin
        in_range = (coarse <= COARSE_W'(COARSE_MAX)) && (fine <= FINE_W'(FINE_MAX));
    end
endmodule

// File: rtl/dtc_tap_fill.sv
`timescale 1ns/1ps
// Takes a full element worth of taps from the remainder, or whatever is left.
module dtc_tap_fill #(
    parameter int REM_W = 13,
    parameter int TAP_W = 5
) (
    input  logic [REM_W-1:0] rem,
    output logic [TAP_W-1:0] taps,
    output logic [REM_W-1:0] rem_next
);
    localparam int TAP_MAX = (1 << TAP_W) - 1;

    always_comb begin
        if (rem >= REM_W'(TAP_MAX)) begin
            taps = TAP_W'(TAP_MAX);
        end else begin
            taps = rem[TAP_W-1:0];
        end
        rem_next = rem - REM_W'(taps);
    end
endmodule

// File: rtl/dtc_elem_cursor.sv
`timescale 1ns/1ps
// Position arithmetic over the two lines: successor, stage boundaries, end.
module dtc_elem_cursor #(
    parameter int N_ELEM = 240,
    parameter int N_FINE = 3,
    parameter int IDX_W  = 8
) (
    input  logic             line,
    input  logic [IDX_W-1:0] idx,
    output logic             nxt_line,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             is_last,
    output logic             nxt_fine_start,
    output logic             nxt_line_start
);
    localparam int N_COARSE = N_ELEM - N_FINE;

    logic at_end;

    always_comb begin
        at_end         = (idx == IDX_W'(N_ELEM - 1));
        is_last        = line && at_end;
        nxt_line_start = at_end;
        if (at_end) begin
            nxt_line = 1'b1;
            nxt_idx  = '0;
        end else begin
            nxt_line = line;
            nxt_idx  = idx + 1'b1;
        end
        nxt_fine_start = (nxt_idx == IDX_W'(N_COARSE));
    end
endmodule

// File: rtl/dtc_tap_sequencer.sv
`timescale 1ns/1ps
// Streams per-element tap settings for a coarse+fine Vernier delay-line pair.
module dtc_tap_sequencer #(
    parameter int N_ELEM = 240,
    parameter int N_FINE = 3,
    parameter int TAP_W  = 5,
    localparam int N_COARSE   = N_ELEM - N_FINE,
    localparam int TAP_MAX    = (1 << TAP_W) - 1,
    localparam int COARSE_MAX = N_COARSE * TAP_MAX,
    localparam int FINE_MAX   = N_FINE * TAP_MAX,
    localparam int IDX_W      = $clog2(N_ELEM),
    localparam int COARSE_W   = $clog2(COARSE_MAX + 1),
    localparam int FINE_W     = $clog2(FINE_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [COARSE_W-1:0] req_coarse,
    input  logic [FINE_W-1:0]   req_fine,
    output logic                req_ready,
    output logic                err,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                out_line,
    output logic [IDX_W-1:0]    out_index,
    output logic [TAP_W-1:0]    out_taps,
    output logic                done
);
    import dtc_pkg::*;

    localparam int REM_W = (COARSE_W > FINE_W) ? COARSE_W : FINE_W;

    typedef struct packed {
        seq_state_e          state;
        logic                line;
        logic [IDX_W-1:0]    idx;
        logic [REM_W-1:0]    rem;
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
        logic                done;
        logic                err;
    } seq_regs_t;

    seq_regs_t q, d;

    logic             req_ok;
    logic [TAP_W-1:0] fill_taps;
    logic [REM_W-1:0] fill_rem_next;
    logic             cur_nxt_line;
    logic [IDX_W-1:0] cur_nxt_idx;
    logic             cur_is_last;
    logic             cur_nxt_fine_start;
    logic             cur_nxt_line_start;

    dtc_req_check #(
        .COARSE_W  (COARSE_W),
        .FINE_W    (FINE_W),
        .COARSE_MAX(COARSE_MAX),
        .FINE_MAX  (FINE_MAX)
    ) u_check (
        .coarse  (req_coarse),
        .fine    (req_fine),
        .in_range(req_ok)
    );

    dtc_tap_fill #(
        .REM_W(REM_W),
        .TAP_W(TAP_W)
    ) u_fill (
        .rem     (q.rem),
        .taps    (fill_taps),
        .rem_next(fill_rem_next)
    );

    dtc_elem_cursor #(
        .N_ELEM(N_ELEM),
        .N_FINE(N_FINE),
        .IDX_W (IDX_W)
    ) u_cursor (
        .line          (q.line),
        .idx           (q.idx),
        .nxt_line      (cur_nxt_line),
        .nxt_idx       (cur_nxt_idx),
        .is_last       (cur_is_last),
        .nxt_fine_start(cur_nxt_fine_start),
        .nxt_line_start(cur_nxt_line_start)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_ok) begin
                        d.state  = ST_STREAM;
                        d.line   = 1'b0;
                        d.idx    = '0;
                        // leading coarse stage draws from an empty remainder
                        d.rem    = '0;
                        d.coarse = req_coarse;
                        d.fine   = req_fine;
                    end else begin
                        d.err = 1'b1;
                    end
                end
            end
            ST_STREAM: begin
                if (out_ready) begin
                    if (cur_is_last) begin
                        d.state = ST_DONE;
                        d.done  = 1'b1;
                    end else begin
                        d.line = cur_nxt_line;
                        d.idx  = cur_nxt_idx;
                        if (cur_nxt_fine_start) begin
                            d.rem = REM_W'(q.fine);
                        end else if (cur_nxt_line_start) begin
                            d.rem = REM_W'(q.coarse);
                        end else begin
                            d.rem = fill_rem_next;
                        end
                    end
                end
            end
            ST_DONE: begin
                d.state = ST_IDLE;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{state: ST_IDLE, line: 1'b0, idx: '0, rem: '0,
                   coarse: '0, fine: '0, done: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        req_ready = (q.state == ST_IDLE);
        out_valid = (q.state == ST_STREAM);
        out_line  = q.line;
        out_index = q.idx;
        out_taps  = fill_taps;
        done      = q.done;
        err       = q.err;
    end
endmodule

// File: rtl/dtc_tap_seq_checker.sv
`timescale 1ns/1ps
module dtc_tap_seq_checker #(
    parameter int N_ELEM = 240,
    parameter int N_FINE = 3,
    parameter int TAP_W  = 5,
    parameter int IDX_W  = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             err,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_line,
    input logic [IDX_W-1:0] out_index,
    input logic [TAP_W-1:0] out_taps,
    input logic             done
);
    localparam int N_COARSE = N_ELEM - N_FINE;

    AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> req_ready && !out_valid && !done && !err); // R1

    AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !(out_line && out_index == IDX_W'(N_ELEM - 1)) |=>
        out_valid && ((out_line == $past(out_line) && out_index == IDX_W'($past(out_index) + 1'b1)) ||
                      (out_line && !$past(out_line) && out_index == '0))); // R2

    AST_LEAD_COARSE_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_line && out_index < IDX_W'(N_COARSE) |-> out_taps == '0); // R3

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_line) && $stable(out_index) && $stable(out_taps)); // R6

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !req_ready); // R7

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        req_ready && !req_valid |=> req_ready && !out_valid && !err); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && req_ready); // R8

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(out_valid && out_ready && out_line && out_index == IDX_W'(N_ELEM - 1))); // R8

    AST_ERR_NO_STREAM: assert property (@(posedge clk) disable iff (rst)
        err |-> req_ready && !out_valid); // R9

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        err |=> !err || $past(req_valid)); // R9
endmodule

bind dtc_tap_sequencer dtc_tap_seq_checker #(
    .N_ELEM(N_ELEM),
    .N_FINE(N_FINE),
    .TAP_W (TAP_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .err      (err),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_line (out_line),
    .out_index(out_index),
    .out_taps (out_taps),
    .done     (done)
);

// File: tb/sim_dtc_tap_sequencer.sv
`timescale 1ns/1ps
module sim_dtc_tap_sequencer;
    localparam int NE    = 240;
    localparam int NC    = 237;
    localparam int TMAX  = 31;
    localparam int CMAX  = NC * TMAX;
    localparam int FMAX  = 3 * TMAX;
    localparam int BEATS = 2 * NE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [12:0] req_coarse = '0;
    logic [6:0]  req_fine = '0;
    logic        req_ready;
    logic        err;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_line;
    logic [7:0]  out_index;
    logic [4:0]  out_taps;
    logic        done;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    dtc_tap_sequencer u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_coarse(req_coarse),
        .req_fine(req_fine), .req_ready(req_ready), .err(err),
        .out_valid(out_valid), .out_ready(out_ready), .out_line(out_line),
        .out_index(out_index), .out_taps(out_taps), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int fill(input int cnt, input int k);
        int r = cnt - TMAX * k;
        if (r <= 0) return 0;
        if (r > TMAX) return TMAX;
        return r;
    endfunction

    function automatic int exp_taps(input int line, input int idx, input int c, input int f);
        if (idx >= NC) return fill(f, idx - NC);
        if (line == 0) return 0;
        return fill(c, idx);
    endfunction

    function automatic string region(input int line, input int idx);
        if (idx >= NC) return "R5 fine";
        if (line == 0) return "R3 lead coarse";
        return "R4 trail coarse";
    endfunction

    task automatic run_request(input int c, input int f, input int pct, input bit poke);
        int  n = 0;
        int  guard = 0;
        bit  acc;
        bit  stalled = 1'b0;
        int  prev_code = 0;
        int  lead_sum = 0;
        int  trail_sum = 0;
        int  lead_fine = 0;
        int  trail_fine = 0;
        chk(req_ready == 1'b1, "R7 ready when idle", int'(req_ready), 1);
        req_valid  = 1'b1;
        req_coarse = 13'(c);
        req_fine   = 7'(f);
        @(negedge clk);
        req_valid = 1'b0;
        while (n < BEATS && guard < 20000) begin
            int eline = n / NE;
            int eidx  = n % NE;
            int et    = exp_taps(eline, eidx, c, f);
            int code  = int'(out_line) * 100000 + int'(out_index) * 100 + int'(out_taps);
            int ecode = eline * 100000 + eidx * 100 + et;
            guard++;
            chk(out_valid == 1'b1, "R2 beat present", int'(out_valid), 1);
            chk(code == ecode, region(eline, eidx), code, ecode);
            chk(req_ready == 1'b0, "R7 not ready while busy", int'(req_ready), 0);
            if (stalled) chk(code == prev_code, "R6 stall holds beat", code, prev_code);
            if (poke) begin
                req_valid  = ($urandom_range(99, 0) < 40);
                req_coarse = 13'($urandom_range(8191, 0));
                req_fine   = 7'($urandom_range(127, 0));
            end
            out_ready = ($urandom_range(99, 0) < pct);
            acc       = out_ready && out_valid;
            stalled   = !out_ready;
            prev_code = code;
            @(negedge clk);
            if (acc) begin
                if (out_line == 1'b0 && n < NE) begin end
                if (eline == 0) lead_sum += int'(et);
                else trail_sum += int'(et);
                if (eidx >= NC && eline == 0) lead_fine += et;
                if (eidx >= NC && eline == 1) trail_fine += et;
                n++;
            end
        end
        req_valid = 1'b0;
        out_ready = 1'b0;
        chk(n == BEATS, "R2 beat count", n, BEATS);
        chk(done == 1'b1, "R8 done after final beat", int'(done), 1);
        chk(out_valid == 1'b0, "R2 no extra beat", int'(out_valid), 0);
        chk(trail_sum - lead_sum == c + 0 * f + (trail_fine - lead_fine),
            "R4 line difference equals coarse", trail_sum - lead_sum, c);
        chk(lead_fine == trail_fine, "R5 fine totals equal", trail_fine, lead_fine);
        chk(lead_fine == f, "R5 fine total", lead_fine, f);
        @(negedge clk);
        chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
        chk(req_ready == 1'b1, "R8 idle after done", int'(req_ready), 1);
    endtask

    task automatic bad_request(input int c, input int f);
        req_valid  = 1'b1;
        req_coarse = 13'(c);
        req_fine   = 7'(f);
        @(negedge clk);
        req_valid = 1'b0;
        chk(err == 1'b1, "R9 err pulse", int'(err), 1);
        chk(out_valid == 1'b0, "R9 no beats", int'(out_valid), 0);
        @(negedge clk);
        chk(err == 1'b0, "R9 err single cycle", int'(err), 0);
        chk(out_valid == 1'b0, "R9 still no beats", int'(out_valid), 0);
        chk(req_ready == 1'b1, "R9 stays idle", int'(req_ready), 1);
    endtask

    initial begin
        void'($urandom(32'h5EED_0D7C));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
        chk(out_valid == 1'b0, "R1 reset no beat", int'(out_valid), 0);
        chk(done == 1'b0, "R1 reset done low", int'(done), 0);
        chk(err == 1'b0, "R1 reset err low", int'(err), 0);

        run_request(0, 0, 100, 1'b0);
        run_request(CMAX, FMAX, 50, 1'b1);
        run_request(31, 31, 70, 1'b0);
        run_request(32, 32, 60, 1'b1);
        run_request(1, 1, 100, 1'b0);
        bad_request(CMAX + 1, 0);
        bad_request(0, FMAX + 1);
        bad_request(8191, 127);
        for (int i = 0; i < 6; i++) begin
            run_request($urandom_range(CMAX, 0), $urandom_range(FMAX, 0),
                        $urandom_range(100, 30), 1'b1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule